// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous DRAM interface and walks the memory from power-on to its idle state. Once reset is released it holds the command pins at no-operation, with clock enable and the data mask high, for a long settling interval. It then closes every bank with one precharge, issues a train of auto-refresh commands, loads the mode word into the memory's mode register, and raises a done flag after a short lockout.

All intervals are parameters given in clock cycles: the settling hold, the precharge-to-refresh wait, the refresh-to-refresh spacing, the refresh count and the lockout after the mode write. The mode word is a parameter too, and it appears on the address bus only during the mode write. A controller for normal traffic waits for done before taking over the pins.

Command pins use the usual active-low encoding {cs_n, ras_n, cas_n, we_n}: no-operation 4'b0111, precharge 4'b0010, auto-refresh 4'b0001, mode register write 4'b0000. Cycle 0 is the cycle between reset release and the first rising edge; cycle k is the output after the k-th rising edge that follows.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low and in cycle 0, the pins read no-operation (4'b0111), the address is zero and done is low; cke and dqm are high in every cycle.
- R2: Cycles 0 to STABLE_CYC-1 carry no-operation; the first other command is issued in cycle STABLE_CYC.
- R3: That first command is a precharge (4'b0010) with address bit 10 high and every other address bit low, so all banks are closed.
- R4: The first auto-refresh (4'b0001) is issued exactly TRP_CYC cycles after the precharge, with the address at zero.
- R5: Exactly REF_COUNT auto-refresh commands are issued (REF_COUNT is at least 8), each TRC_CYC cycles after the one before.
- R6: A mode register write (4'b0000) follows the last auto-refresh by TRC_CYC cycles, with MODE_WORD on the full address bus.
- R7: Each command lasts one cycle; every other cycle, including all cycles after the mode write, carries no-operation.
- R8: Done rises LOCK_CYC+1 cycles after the mode write, so LOCK_CYC full no-operation cycles pass first, and stays high until the next reset.
- R9: A reset at any point returns the outputs to the R1 state and the sequence restarts from cycle 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the memory |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | 1 | Data mask to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus: bank selector bit for precharge, mode word for the mode write |
| done | output | 1 | High once the memory is ready for normal traffic |

## Verification
The bench builds the block with a 40-cycle settling hold, a 3-cycle precharge wait, 6-cycle refresh spacing, nine refreshes, a 2-cycle lockout and the mode word 14'h0232, in place of the tens of thousands of cycles a real settling hold needs. These values put the whole sequence inside about a hundred cycles, so every command's cycle, the refresh count one above the minimum, the exact rise of done and its persistence can all be read from one recorded trace. The distinct spacings and the restart after a reset taken midway through the refresh train make an off-by-one in any interval, or a state left over from a prior run, show up as a shifted command cycle.

// File: rtl/sdram_init_pkg.sv
// Package: shared command encoding for the initialization sequencer.
// Assumes the usual active-low pin order {cs_n, ras_n, cas_n, we_n}.
package sdram_init_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001,
        CMD_MRS = 4'b0000
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        ST_SETTLE,
        ST_PRE_WAIT,
        ST_REF_WAIT,
        ST_LOCKOUT,
        ST_READY
    } init_state_e;

    // Larger of two non-negative counts.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
// Module: down-counter that measures the gap before the next command.
// Starts at RST_VAL after reset, reloads on load, holds at zero.
// Assumes load_val fits in W bits.
module sdram_init_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Count down toward zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= W'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // A reload always comes from an expired count: no gap is cut short.
    assert_reload_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> expired);
endmodule

// File: rtl/sdram_init_refcnt.sv
// Module: tally of auto-refresh commands issued since reset.
// all_issued goes high once REF_COUNT refreshes have been sent.
// Assumes inc is never raised after all_issued.
module sdram_init_refcnt #(
    parameter int REF_COUNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    output logic all_issued
);
    localparam int RW = $clog2(REF_COUNT + 1);

    logic [RW-1:0] tally_q;

    // Count refreshes issued.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tally_q <= '0;
        else if (inc)
            tally_q <= tally_q + 1'b1;
    end

    assign all_issued = (tally_q == RW'(REF_COUNT));

    // Never more refreshes than configured.
    assert_no_extra_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
        all_issued |-> !inc);
endmodule

// File: rtl/sdram_init_cmdenc.sv
// Module: registers the command pins and the address bus.
// Precharge drives only the all-banks bit, mode write drives MODE_WORD,
// everything else drives zero. Assumes ADDR_W > 10.
module sdram_init_cmdenc
    import sdram_init_pkg::*;
#(
    parameter int              ADDR_W    = 14,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sdram_cmd_e        cmd_sel,
    output logic [3:0]        pins,
    output logic [ADDR_W-1:0] addr
);
    localparam int ALLBANK_BIT = 10;

    logic [ADDR_W-1:0] addr_d;

    // Pick the address that goes with the chosen command.
    always_comb begin
        addr_d = '0;
        unique case (cmd_sel)
            CMD_PRE: addr_d[ALLBANK_BIT] = 1'b1;
            CMD_MRS: addr_d = MODE_WORD;
            default: addr_d = '0;
        endcase
    end

    // Register pins and address so they change only at a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins <= CMD_NOP;
            addr <= '0;
        end else begin
            pins <= cmd_sel;
            addr <= addr_d;
        end
    end

    // Precharge carries the all-banks bit and nothing else.
    assert_pre_allbank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == CMD_PRE) |-> (addr == (ADDR_W'(1) << ALLBANK_BIT)));
    // The mode write carries the mode word.
    assert_mrs_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == CMD_MRS) |-> (addr == MODE_WORD));
endmodule

// File: rtl/sdram_init_seq.sv
// Module: top of the power-up sequencer. Holds no-operation for
// STABLE_CYC cycles, then issues precharge-all, REF_COUNT refreshes and a
// mode write at the configured spacings, then raises done after LOCK_CYC
// idle cycles. Assumes all gaps >= 1 and REF_COUNT >= 8.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int                STABLE_CYC = 50000,
    parameter int                TRP_CYC    = 5,
    parameter int                TRC_CYC    = 16,
    parameter int                REF_COUNT  = 8,
    parameter int                LOCK_CYC   = 2,
    parameter int                ADDR_W     = 14,
    parameter logic [ADDR_W-1:0] MODE_WORD  = 14'h0032
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cke,
    output logic              dqm,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    localparam int MAX_GAP = max2(max2(STABLE_CYC, TRP_CYC), max2(TRC_CYC, LOCK_CYC + 1));
    localparam int CNT_W   = $clog2(MAX_GAP + 1);

    init_state_e       state_q, state_d;
    sdram_cmd_e        cmd_d;
    logic              load;
    logic [CNT_W-1:0]  load_val;
    logic              expired;
    logic              ref_inc;
    logic              all_refs;
    logic              done_d;
    logic [3:0]        pins;

    sdram_init_timer #(.W(CNT_W), .RST_VAL(STABLE_CYC - 1)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
    );

    sdram_init_refcnt #(.REF_COUNT(REF_COUNT)) u_refcnt (
        .clk(clk), .rst_n(rst_n), .inc(ref_inc), .all_issued(all_refs)
    );

    sdram_init_cmdenc #(.ADDR_W(ADDR_W), .MODE_WORD(MODE_WORD)) u_enc (
        .clk(clk), .rst_n(rst_n), .cmd_sel(cmd_d), .pins(pins), .addr(addr)
    );

    assign {cs_n, ras_n, cas_n, we_n} = pins;

    // Choose the next command and gap when the current wait runs out.
    always_comb begin
        state_d  = state_q;
        cmd_d    = CMD_NOP;
        load     = 1'b0;
        load_val = '0;
        ref_inc  = 1'b0;
        done_d   = 1'b0;
        if (expired) begin
            unique case (state_q)
                ST_SETTLE: begin
                    cmd_d    = CMD_PRE;
                    load     = 1'b1;
                    load_val = CNT_W'(TRP_CYC - 1);
                    state_d  = ST_PRE_WAIT;
                end
                ST_PRE_WAIT: begin
                    cmd_d    = CMD_REF;
                    ref_inc  = 1'b1;
                    load     = 1'b1;
                    load_val = CNT_W'(TRC_CYC - 1);
                    state_d  = ST_REF_WAIT;
                end
                ST_REF_WAIT: begin
                    load = 1'b1;
                    if (all_refs) begin
                        cmd_d    = CMD_MRS;
                        load_val = CNT_W'(LOCK_CYC);
                        state_d  = ST_LOCKOUT;
                    end else begin
                        cmd_d    = CMD_REF;
                        ref_inc  = 1'b1;
                        load_val = CNT_W'(TRC_CYC - 1);
                    end
                end
                ST_LOCKOUT: begin
                    done_d  = 1'b1;
                    state_d = ST_READY;
                end
                default: state_d = ST_READY;
            endcase
        end
    end

    // Sequence state, done flag and the static pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;
            done    <= 1'b0;
            cke     <= 1'b1;
            dqm     <= 1'b1;
        end else begin
            state_q <= state_d;
            done    <= done | done_d;
            cke     <= 1'b1;
            dqm     <= 1'b1;
        end
    end

    // ---------------- checker state and assertions ----------------
    logic [31:0] chk_boot;   // cycle index since reset release
    logic [31:0] chk_since;  // cycles since the last command
    logic [3:0]  chk_last;   // last command seen
    logic [31:0] chk_refs;   // refreshes seen

    // Track elapsed cycles and the command history at the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_boot  <= 32'd1;
            chk_since <= 32'd1;
            chk_last  <= CMD_NOP;
            chk_refs  <= '0;
        end else begin
            if (chk_boot != '1) chk_boot <= chk_boot + 1;
            if (pins != CMD_NOP) begin
                chk_since <= 32'd1;
                chk_last  <= pins;
            end else if (chk_since != '1) begin
                chk_since <= chk_since + 1;
            end
            if (pins == CMD_REF) chk_refs <= chk_refs + 1;
        end
    end

    assert_pre_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == CMD_PRE) |-> (chk_boot == 32'(STABLE_CYC + 1) && chk_last == CMD_NOP));
    assert_first_ref_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == CMD_REF && chk_last == CMD_PRE) |-> (chk_since == 32'(TRP_CYC)));
    assert_ref_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == CMD_REF && chk_last == CMD_REF) |-> (chk_since == 32'(TRC_CYC)));
    assert_mrs_after_refs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == CMD_MRS) |-> (chk_refs == 32'(REF_COUNT) && chk_last == CMD_REF
                               && chk_since == 32'(TRC_CYC)));
    assert_one_cycle_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pins != CMD_NOP) |=> (pins == CMD_NOP));
    assert_done_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (chk_last == CMD_MRS && chk_since == 32'(LOCK_CYC + 1)));
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    assert_quiet_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pins == CMD_NOP));
endmodule

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;
    localparam int STABLE = 40;
    localparam int TRP    = 3;
    localparam int TRC    = 6;
    localparam int NREF   = 9;
    localparam int LOCK   = 2;
    localparam int AW     = 14;
    localparam logic [AW-1:0] MODE = 14'h0232;
    localparam logic [3:0] P_NOP = 4'b0111, P_PRE = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke, dqm, cs_n, ras_n, cas_n, we_n, done;
    logic [AW-1:0] addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sdram_init_seq #(
        .STABLE_CYC(STABLE), .TRP_CYC(TRP), .TRC_CYC(TRC), .REF_COUNT(NREF),
        .LOCK_CYC(LOCK), .ADDR_W(AW), .MODE_WORD(MODE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke), .dqm(dqm), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .done(done)
    );

    function automatic logic [3:0] pins();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R1, R9: outputs held in reset.
    task automatic t_reset_state(input string req);
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(pins() == P_NOP, req, "pins in reset", pins(), P_NOP);
        check(addr == '0, req, "addr in reset", addr, 0);
        check(done == 1'b0, req, "done in reset", done, 0);
        check(cke && dqm, req, "cke/dqm in reset", {cke, dqm}, 2'b11);
    endtask

    // Full run from reset release, recording the command trace.
    task automatic t_full_sequence();
        int cmd_cyc[32];
        logic [3:0] cmd_kind[32];
        logic [AW-1:0] cmd_addr[32];
        int n = 0;
        int first_done = -1;
        bit lost_done = 0, busy_done = 0, low_ctl = 0;
        int exp_cyc;
        rst_n = 1'b1;  // released at a falling edge: this is cycle 0
        check(pins() == P_NOP && addr == '0 && !done, "R1", "cycle 0 state",
              {pins(), done}, {P_NOP, 1'b0});
        for (int cyc = 0; cyc <= 130; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (!(cke && dqm)) low_ctl = 1;
            if (pins() != P_NOP && n < 32) begin
                cmd_cyc[n] = cyc; cmd_kind[n] = pins(); cmd_addr[n] = addr; n++;
            end
            if (done && first_done < 0) first_done = cyc;
            if (first_done >= 0 && !done) lost_done = 1;
            if (done && pins() != P_NOP) busy_done = 1;
        end
        check(!low_ctl, "R1", "cke/dqm stayed high", low_ctl, 0);
        check(n == NREF + 2, "R7", "command count", n, NREF + 2);
        if (n == NREF + 2) begin
            check(cmd_kind[0] == P_PRE, "R3", "first command", cmd_kind[0], P_PRE);
            check(cmd_cyc[0] == STABLE, "R2", "precharge cycle", cmd_cyc[0], STABLE);
            check(cmd_addr[0] == 14'h0400, "R3", "precharge addr", cmd_addr[0], 14'h0400);
            exp_cyc = STABLE + TRP;
            for (int i = 1; i <= NREF; i++) begin
                check(cmd_kind[i] == P_REF, (i == 1) ? "R4" : "R5", "refresh kind",
                      cmd_kind[i], P_REF);
                check(cmd_cyc[i] == exp_cyc, (i == 1) ? "R4" : "R5", "refresh cycle",
                      cmd_cyc[i], exp_cyc);
                check(cmd_addr[i] == '0, "R4", "refresh addr", cmd_addr[i], 0);
                exp_cyc += TRC;
            end
            check(cmd_kind[NREF + 1] == P_MRS, "R6", "mode write kind", cmd_kind[NREF + 1], P_MRS);
            check(cmd_cyc[NREF + 1] == exp_cyc, "R6", "mode write cycle", cmd_cyc[NREF + 1], exp_cyc);
            check(cmd_addr[NREF + 1] == MODE, "R6", "mode word", cmd_addr[NREF + 1], MODE);
            check(first_done == exp_cyc + LOCK + 1, "R8", "done rise cycle",
                  first_done, exp_cyc + LOCK + 1);
        end
        check(!lost_done, "R8", "done stayed high", lost_done, 0);
        check(!busy_done, "R7", "no command after done", busy_done, 0);
    endtask

    // R9: reset in the middle of the refresh train restarts everything.
    task automatic t_restart();
        int pre_at = -1;
        rst_n = 1'b1;
        repeat (60) @(negedge clk);
        t_reset_state("R9");
        rst_n = 1'b1;
        for (int cyc = 0; cyc <= STABLE + 5; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (pins() != P_NOP && pre_at < 0) begin
                pre_at = cyc;
                check(pins() == P_PRE, "R9", "restart first command", pins(), P_PRE);
            end
        end
        check(pre_at == STABLE, "R9", "restart precharge cycle", pre_at, STABLE);
    endtask

    initial begin
        t_reset_state("R1");
        t_full_sequence();
        t_restart();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule